// File: doc/BRIEF.md
# Return-to-Zero Oversampling Bit Receiver

This block recovers bits from a single return-to-zero serial line running at 5 Mbit/s, which gives 200 ns per bit. A one is sent as a high first half followed by a low second half. A zero is low for both halves. The block runs on a 120 MHz clock, so each 100 ns half-bit lasts twelve clock cycles. The line first passes through a two-stage synchroniser. A twelve-state phase counter then takes exactly one sample per half-bit.

A protocol controller drives `recordMode`.
- While `recordMode` is low, the block is in trigger mode. The phase counter is held clear, any half-finished bit is discarded, and nothing is written.
- While `recordMode` is high, the receiver first waits for the rising edge that opens a message. It then locks its sampling phase six cycles into each half-bit and records continuously.

Samples are paired into bits. Each pair (first half, second half) is pushed into a 16-entry register FIFO. The FIFO head is always visible on the outputs. The first-half level is the bit value. A high second half is a coding violation and is reported beside the bit.

Top module: `rz_bit_receiver`

## Requirements
- R1: After reset `fifoEmpty` is 1, `fifoFull` is 0, `overflow` is 0 and `phaseLocked` is 0.
- R2: With `recordMode` high and the receiver unlocked, `phaseLocked` rises on the third rising clock edge after the first edge that sees `lineIn` high. While `lineIn` stays low, the receiver stays unlocked.
- R3: After locking, the first sample is taken 6 cycles after the lock edge. Every following sample comes exactly 12 cycles after the previous one. No sample is taken while unlocked. As a result, the first bit of a message is written on the 21st rising edge after the line is first seen high.
- R4: Each FIFO entry holds one bit. `popBit` is the first-half sample, so 1 means high-then-low and 0 means low-low.
- R5: `popErr` is 1 when the second-half sample of that bit was high, which is a coding violation. Otherwise it is 0.
- R6: Once locked, further rising edges on the line do not re-lock or shift the sampling phase.
- R7: With `recordMode` low, `phaseLocked` is 0 one cycle later and no entry is written, whatever the line does. The next message re-locks from its own first rising edge.
- R8: The FIFO keeps the order of arrival. The head is shown on `popBit`/`popErr` whenever `fifoEmpty` is 0. `popReq` removes the head at the clock edge. `fifoFull` and `fifoEmpty` are never both 1.
- R9: After 16 unread entries, `fifoFull` is 1. A bit completed while full is dropped and sets `overflow`, which stays 1 until reset.
- R10: `popReq` while the FIFO is empty has no effect on the flags or on later data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 120 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Serial line after optical-to-electrical conversion (asynchronous) |
| recordMode | input | 1 | 0 = trigger mode (cleared, waiting); 1 = lock on the next rising edge, then record |
| popReq | input | 1 | Removes the FIFO head at the next clock edge |
| popBit | output | 1 | Bit value of the FIFO head |
| popErr | output | 1 | Coding violation flag of the FIFO head |
| fifoEmpty | output | 1 | FIFO holds no entries |
| fifoFull | output | 1 | FIFO holds 16 entries |
| overflow | output | 1 | Sticky: a bit was dropped because the FIFO was full |
| phaseLocked | output | 1 | Sampling phase is locked to the current message |

## Verification
Each result has a fixed arrival time, counted from the first clock edge that sees the line high:
- Lock follows at the third edge.
- The first sample is six edges after that.
- The first bit reaches the FIFO at the 21st edge. Each later bit arrives 24 edges after the one before it.
- FIFO head data and flags change at the edge of a push or pop.
- Leaving record mode drops the lock at the next edge.

The bench drives `lineIn` one half-bit at a time, twelve cycles per half. It changes inputs and reads outputs only on the falling clock edge, and it counts edges explicitly to look at the exact cycles on either side of each expected change. In particular it returns to trigger mode right after the last half of a message, before the next sample, so the number of entries written is known exactly.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;

  // Strobes from the phase controller to the datapath.
  typedef struct packed {
    logic sampleStb;   // take one sample of the synchronised line this cycle
    logic pairClear;   // discard any half-collected bit
  } rzrxStrobe_t;

  // One received bit as its two half-bit samples.
  typedef struct packed {
    logic firstHalf;
    logic secondHalf;
  } rzrxPair_t;

endpackage

// File: rtl/rzrx_fifo.sv
module rzrx_fifo
  import rzrx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pushEn,
  input  rzrxPair_t pushData,
  input  logic      popEn,
  output rzrxPair_t headData,
  output logic      empty,
  output logic      full,
  output logic      overflow
);

  localparam int AW = $clog2(DEPTH);

  logic [AW:0] wrPtr;
  logic [AW:0] rdPtr;
  rzrxPair_t   mem [DEPTH];

  logic doPush;
  logic doPop;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + (AW+1)'(1);
      if (doPop)  rdPtr <= rdPtr + (AW+1)'(1);
      if (pushEn && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= pushData;
  end

  assign headData = mem[rdPtr[AW-1:0]];

endmodule

// File: rtl/rzrx_ctrl.sv
module rzrx_ctrl
  import rzrx_pkg::*;
#(
  parameter int PHASE_CYCLES = 12,
  parameter int TRIG_OFFSET  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        recordMode,
  input  logic        lineRise,
  output rzrxStrobe_t stb,
  output logic        phaseLocked
);

  localparam int              CW         = $clog2(PHASE_CYCLES);
  localparam logic [CW-1:0]   PHASE_LAST = CW'(PHASE_CYCLES - 1);
  localparam logic [CW-1:0]   PHASE_LOAD = CW'(PHASE_CYCLES - TRIG_OFFSET);

  typedef enum logic {ST_ARMED, ST_RECORD} rxState_e;

  rxState_e      state;
  logic [CW-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ARMED;
      phaseCnt <= '0;
    end else if (!recordMode) begin
      state    <= ST_ARMED;
      phaseCnt <= '0;
    end else if (state == ST_ARMED) begin
      if (lineRise) begin
        state    <= ST_RECORD;
        phaseCnt <= PHASE_LOAD;
      end
    end else begin
      phaseCnt <= (phaseCnt == PHASE_LAST) ? '0 : phaseCnt + CW'(1);
    end
  end

  always_comb begin
    stb.sampleStb = (state == ST_RECORD) && recordMode && (phaseCnt == PHASE_LAST);
    stb.pairClear = !recordMode || (state == ST_ARMED);
  end

  assign phaseLocked = (state == ST_RECORD);

endmodule

// File: rtl/rzrx_datapath.sv
module rzrx_datapath
  import rzrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lineIn,
  input  rzrxStrobe_t stb,
  input  logic        popReq,
  output logic        lineRise,
  output logic        popBit,
  output logic        popErr,
  output logic        fifoEmpty,
  output logic        fifoFull,
  output logic        overflow
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineSync;
  logic                   lineSyncD;
  logic                   halfSel;
  logic                   firstReg;
  logic                   pushEn;
  rzrxPair_t              pushData;
  rzrxPair_t              headData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain <= '0;
      lineSyncD <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], lineIn};
      lineSyncD <= lineSync;
    end
  end

  assign lineSync = syncChain[SYNC_STAGES-1];
  assign lineRise = lineSync && !lineSyncD;

  // Pair successive half-bit samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfSel  <= 1'b0;
      firstReg <= 1'b0;
    end else if (stb.pairClear) begin
      halfSel  <= 1'b0;
    end else if (stb.sampleStb) begin
      if (!halfSel) firstReg <= lineSync;
      halfSel <= !halfSel;
    end
  end

  assign pushEn             = stb.sampleStb && halfSel && !stb.pairClear;
  assign pushData.firstHalf  = firstReg;
  assign pushData.secondHalf = lineSync;

  rzrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .pushEn   (pushEn),
    .pushData (pushData),
    .popEn    (popReq),
    .headData (headData),
    .empty    (fifoEmpty),
    .full     (fifoFull),
    .overflow (overflow)
  );

  assign popBit = headData.firstHalf;
  assign popErr = headData.secondHalf;

endmodule

// File: rtl/rz_bit_receiver.sv
module rz_bit_receiver
  import rzrx_pkg::*;
#(
  parameter int PHASE_CYCLES = 12,
  parameter int TRIG_OFFSET  = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int FIFO_DEPTH   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  input  logic recordMode,
  input  logic popReq,
  output logic popBit,
  output logic popErr,
  output logic fifoEmpty,
  output logic fifoFull,
  output logic overflow,
  output logic phaseLocked
);

  rzrxStrobe_t ctrlStb;
  logic        lineRise;
  logic        sampleStb;

  rzrx_ctrl #(
    .PHASE_CYCLES (PHASE_CYCLES),
    .TRIG_OFFSET  (TRIG_OFFSET)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .recordMode  (recordMode),
    .lineRise    (lineRise),
    .stb         (ctrlStb),
    .phaseLocked (phaseLocked)
  );

  rzrx_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FIFO_DEPTH  (FIFO_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lineIn    (lineIn),
    .stb       (ctrlStb),
    .popReq    (popReq),
    .lineRise  (lineRise),
    .popBit    (popBit),
    .popErr    (popErr),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .overflow  (overflow)
  );

  assign sampleStb = ctrlStb.sampleStb;

endmodule

// File: rtl/rz_bit_receiver_chk.sv
module rz_bit_receiver_chk #(
  parameter int PHASE_CYCLES = 12,
  parameter int TRIG_OFFSET  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic recordMode,
  input logic phaseLocked,
  input logic sampleStb,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic overflow
);

  logic [15:0] gapCnt;
  logic        seenStb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt  <= '0;
      seenStb <= 1'b0;
    end else if (!phaseLocked) begin
      gapCnt  <= '0;
      seenStb <= 1'b0;
    end else if (sampleStb) begin
      gapCnt  <= '0;
      seenStb <= 1'b1;
    end else begin
      gapCnt  <= gapCnt + 16'd1;
    end
  end

  // R3: samples only while locked
  assert_sample_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> phaseLocked);

  // R3: first sample after the offset, then one per half-bit period
  assert_sample_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> (int'(gapCnt) == (seenStb ? PHASE_CYCLES - 1 : TRIG_OFFSET - 1)));

  // R7: trigger mode drops the lock
  assert_trigger_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !recordMode |=> !phaseLocked);

  // R8: flags never both set
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifoFull && fifoEmpty));

  // R9: overflow is sticky
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: overflow only arises from a full FIFO
  assert_overflow_from_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifoFull));

endmodule

bind rz_bit_receiver rz_bit_receiver_chk #(
  .PHASE_CYCLES (PHASE_CYCLES),
  .TRIG_OFFSET  (TRIG_OFFSET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .recordMode  (recordMode),
  .phaseLocked (phaseLocked),
  .sampleStb   (sampleStb),
  .fifoEmpty   (fifoEmpty),
  .fifoFull    (fifoFull),
  .overflow    (overflow)
);

// File: tb/rz_bit_receiver_tb.sv
module rz_bit_receiver_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CLK_PERIOD = 8;
  localparam int HALF_CYC   = 12;

  typedef struct packed {
    logic [15:0] halves;   // line level per half-bit, MSB sent first
    logic [7:0]  expBits;
    logic [7:0]  expErr;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{16'hAAAA, 8'hFF, 8'h00},
    '{16'h8000, 8'h80, 8'h00},
    '{16'h8A08, 8'hB2, 8'h00},
    '{16'hD8C6, 8'hA9, 8'hCA},
    '{16'h8888, 8'hAA, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineIn = 1'b0;
  logic recordMode = 1'b0;
  logic popReq = 1'b0;
  logic popBit, popErr, fifoEmpty, fifoFull, overflow, phaseLocked;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rz_bit_receiver u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lineIn      (lineIn),
    .recordMode  (recordMode),
    .popReq      (popReq),
    .popBit      (popBit),
    .popErr      (popErr),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .overflow    (overflow),
    .phaseLocked (phaseLocked)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkEq(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic popOne(output logic b, output logic e);
    b = popBit;
    e = popErr;
    popReq = 1'b1;
    tick();
    popReq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    logic b, e;
    repeat (3) @(negedge clk);
    checkEq("R1", "fifoEmpty", fifoEmpty, 1);
    checkEq("R1", "fifoFull", fifoFull, 0);
    checkEq("R1", "overflow", overflow, 0);
    checkEq("R1", "phaseLocked", phaseLocked, 0);
    rst_n = 1'b1;
    tick();

    // Directed: lock and first-write timing
    recordMode = 1'b1;
    repeat (4) tick();
    checkEq("R2", "no lock on idle line", phaseLocked, 0);
    lineIn = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      tick();
      if (k == 2)  checkEq("R2", "lock edge 2", phaseLocked, 0);
      if (k == 3)  checkEq("R2", "lock edge 3", phaseLocked, 1);
      if (k == 20) checkEq("R3", "empty before edge 21", fifoEmpty, 1);
      if (k == 21) checkEq("R3", "written at edge 21", fifoEmpty, 0);
      lineIn = (k < 12);
    end
    recordMode = 1'b0;
    tick();
    checkEq("R7", "unlock in trigger mode", phaseLocked, 0);
    for (int k = 0; k < 60; k++) begin
      lineIn = ((k % 24) < 12);
      tick();
    end
    lineIn = 1'b0;
    repeat (4) tick();
    popOne(b, e);
    checkEq("R4", "single bit value", b, 1);
    checkEq("R5", "single bit no violation", e, 0);
    checkEq("R7", "nothing written in trigger mode", fifoEmpty, 1);

    // Directed: pop on empty
    popReq = 1'b1;
    repeat (3) tick();
    popReq = 1'b0;
    checkEq("R10", "empty after pops", fifoEmpty, 1);
    checkEq("R10", "not full after pops", fifoFull, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      recordMode = 1'b0;
      lineIn = 1'b0;
      repeat (4) tick();
      checkEq("R7", "unlocked between messages", phaseLocked, 0);
      recordMode = 1'b1;
      repeat (3) tick();
      checkEq("R2", "waits for rising edge", phaseLocked, 0);
      for (int h = 0; h < 16; h++) begin
        lineIn = VECS[v].halves[15-h];
        repeat (HALF_CYC) tick();
      end
      lineIn = 1'b0;
      recordMode = 1'b0;
      repeat (3) tick();
      for (int i = 0; i < 8; i++) begin
        checkEq("R8", "entry present", fifoEmpty, 0);
        popOne(b, e);
        checkEq("R4 R6 R8", $sformatf("vec %0d bit %0d", v, i), b, VECS[v].expBits[7-i]);
        checkEq("R5 R6", $sformatf("vec %0d violation %0d", v, i), e, VECS[v].expErr[7-i]);
      end
      checkEq("R8", "drained", fifoEmpty, 1);
    end

    // Directed: overflow
    recordMode = 1'b1;
    repeat (3) tick();
    for (int k = 0; k < 20; k++) begin
      lineIn = (k < 16);
      repeat (HALF_CYC) tick();
      lineIn = 1'b0;
      repeat (HALF_CYC) tick();
    end
    recordMode = 1'b0;
    repeat (3) tick();
    checkEq("R9", "full after 16", fifoFull, 1);
    checkEq("R9", "overflow set", overflow, 1);
    for (int i = 0; i < 16; i++) begin
      popOne(b, e);
      checkEq("R9", $sformatf("kept entry %0d", i), b, 1);
    end
    checkEq("R9", "dropped bits absent", fifoEmpty, 1);
    checkEq("R9", "overflow sticky", overflow, 1);

    finishRun();
  end

endmodule